// File: doc/BRIEF.md
# Parallel Port Microsequencer Engine

This block is a small programmable controller that sits beside a parallel-port register block. A host fills a local instruction memory through a load port, then pulses `start` with an entry address. The engine fetches 32-bit microinstructions one at a time and runs them against the port registers: it writes and modifies registers, stores masked register reads into an external byte buffer, busy-waits on a microsecond tick, loops on a decrementing counter and branches on the port status lines. It can also enter one level of subsequence, and it can play back a list of data/delay pairs into a register.

Execution ends only at an `END` instruction, whose immediate byte is reported on `ret_code` with a one-cycle `done` pulse. A call nested inside a subsequence, a subsequence return outside one, or an undefined opcode stops the run with `fault` set and a dedicated code. The microsecond tick comes from dividing the clock by the `US_DIV` parameter.

Instruction word layout: opcode in bits [31:27], register select in [26:24], field A in [23:16], field B in [15:8], field C in [7:0]. Branch offsets in C are signed and are added to the address of the instruction after the branch.

Top module: `psq_engine`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `reg_we` and `buf_we` are 0 and the engine waits in idle.
- R2: `start` while idle begins execution at `start_addr`; `END` (opcode 10) ends the run with a one-cycle `done`, `busy` low, `fault` 0 and `ret_code` = field A; `start` while busy has no effect.
- R3: `WRREG` (opcode 4) writes field A to the selected register; `MODREG` (opcode 3) reads the register, ORs in field A, then clears the bits of field B, so a bit in both masks ends up 0.
- R4: `RDREG` (opcode 2) writes (selected register AND field A) to buffer address field C.
- R5: `WAIT` (opcode 5) stalls for {B,C} microseconds, i.e. exactly {B,C}×`US_DIV` clock cycles longer than a zero wait, which adds no stall.
- R6: `LDCNT` (opcode 6) loads the loop counter with {B,C}; `DECBR` (opcode 7) decrements it and branches only if the new value is greater than zero as a signed number.
- R7: `BRANY1` (opcode 8) branches when any status bit selected by A is 1; `BRANY0` (opcode 9) branches when any status bit selected by A is 0.
- R8: `BRMATCH` (opcode 14) branches only when all status bits in A are 1 and all status bits in B are 0.
- R9: A taken branch continues at (branch address + 1 + signed C), so C = 0xFE on the instruction after a branch returns to that branch.
- R10: `SUBCALL` (opcode 16) jumps to address C and `SUBEND` (opcode 15) resumes at the instruction after the call.
- R11: `LDPTR` (opcode 12) loads the buffer pointer from C; `STREAMOUT` (opcode 17) writes A consecutive buffer bytes, starting at the pointer, to the selected register, advancing the pointer per byte.
- R12: `STREAMIN` (opcode 18) stores A successive (register AND B) values at the pointer and following addresses, advancing the pointer per byte.
- R13: `PLAY` (opcode 19) with count A treats the next A words as pairs (data in bits [15:8], delay in µs in bits [7:0]); each data byte is written to the selected register and followed by its delay, consecutive writes are 2 + delay×`US_DIV` cycles apart, and execution resumes after the list.
- R14: A `SUBCALL` inside a subsequence stops with `fault`=1 and code 0xE1; an undefined opcode or a `SUBEND` outside a subsequence stops with `fault`=1 and code 0xE2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution (idle only) |
| start_addr | input | IAW | Entry address |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle end pulse |
| ret_code | output | 8 | Return or fault code |
| fault | output | 1 | Run ended abnormally |
| load_we | input | 1 | Instruction memory write enable |
| load_addr | input | IAW | Instruction memory write address |
| load_data | input | 32 | Instruction word |
| reg_raddr | output | 3 | Port register read select |
| reg_rdata | input | 8 | Port register read data, same cycle |
| reg_we | output | 1 | Port register write strobe |
| reg_waddr | output | 3 | Port register write select |
| reg_wdata | output | 8 | Port register write data |
| port_status | input | 8 | Live status lines |
| buf_addr | output | 8 | Buffer address |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data, one cycle after address |

## Verification
The microsecond wait and a fresh `start` can meet in the same cycle: the bench pulses `start` toward another program while a `WAIT` is counting, and judges that the return code and total duration match an undisturbed run. A `PLAY` write and the start of its paired delay also share a cycle; the bench timestamps each register write and compares the spacing against 2 + delay×`US_DIV`, including a zero delay between pairs.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int IW  = 32;
  localparam int DW  = 8;
  localparam int RSW = 3;

  localparam logic [4:0] OP_RDREG    = 5'd2;
  localparam logic [4:0] OP_MODREG   = 5'd3;
  localparam logic [4:0] OP_WRREG    = 5'd4;
  localparam logic [4:0] OP_WAIT     = 5'd5;
  localparam logic [4:0] OP_LDCNT    = 5'd6;
  localparam logic [4:0] OP_DECBR    = 5'd7;
  localparam logic [4:0] OP_BRANY1   = 5'd8;
  localparam logic [4:0] OP_BRANY0   = 5'd9;
  localparam logic [4:0] OP_END      = 5'd10;
  localparam logic [4:0] OP_LDPTR    = 5'd12;
  localparam logic [4:0] OP_BRMATCH  = 5'd14;
  localparam logic [4:0] OP_SUBEND   = 5'd15;
  localparam logic [4:0] OP_SUBCALL  = 5'd16;
  localparam logic [4:0] OP_STREAMO  = 5'd17;
  localparam logic [4:0] OP_STREAMI  = 5'd18;
  localparam logic [4:0] OP_PLAY     = 5'd19;

  localparam logic [DW-1:0] CODE_NEST    = 8'hE1;
  localparam logic [DW-1:0] CODE_ILLEGAL = 8'hE2;

  typedef struct packed {
    logic [4:0]     op;
    logic [RSW-1:0] rsel;
    logic [DW-1:0]  fa;
    logic [DW-1:0]  fb;
    logic [DW-1:0]  fc;
  } instr_t;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_EXEC, S_WAIT, S_BADDR, S_BDATA, S_SIN, S_PFETCH, S_PEXEC
  } state_e;
endpackage

// File: rtl/psq_imem.sv
module psq_imem #(
  parameter int AW = 8,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/psq_ustick.sv
module psq_ustick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/psq_core.sv
module psq_core
  import psq_pkg::*;
#(
  parameter int IAW = 8,
  parameter int BRW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [IAW-1:0] start_addr,
  output logic           busy,
  output logic           done,
  output logic [DW-1:0]  ret_code,
  output logic           fault,
  output logic [IAW-1:0] imem_addr,
  input  logic [IW-1:0]  imem_rdata,
  output logic           tick_run,
  input  logic           tick,
  output logic [RSW-1:0] reg_raddr,
  input  logic [DW-1:0]  reg_rdata,
  output logic           reg_we,
  output logic [RSW-1:0] reg_waddr,
  output logic [DW-1:0]  reg_wdata,
  input  logic [DW-1:0]  port_status,
  output logic [DW-1:0]  buf_addr,
  output logic           buf_we,
  output logic [DW-1:0]  buf_wdata,
  input  logic [DW-1:0]  buf_rdata
);
  state_e                state;
  logic [IAW-1:0]        pc, ret_pc;
  logic                  in_sub, play;
  logic [DW-1:0]         ptr, cnt, r_mask;
  logic [RSW-1:0]        r_sel;
  logic [15:0]           us_left;
  logic signed [BRW-1:0] brc;

  instr_t                ins;
  logic [IAW-1:0]        npc, tgt;
  logic signed [BRW-1:0] brc_dec;
  logic                  take;

  assign ins       = instr_t'(imem_rdata);
  assign npc       = pc + 1'b1;
  assign tgt       = npc + IAW'($signed(ins.fc));
  assign brc_dec   = brc - 1'b1;
  assign imem_addr = pc;
  assign tick_run  = (state == S_WAIT);
  assign busy      = (state != S_IDLE);
  assign reg_raddr = (state == S_EXEC) ? ins.rsel : r_sel;

  always_comb begin
    case (ins.op)
      OP_BRANY1:  take = |(port_status & ins.fa);
      OP_BRANY0:  take = |(~port_status & ins.fa);
      OP_BRMATCH: take = ((port_status & ins.fa) == ins.fa) && ((port_status & ins.fb) == '0);
      OP_DECBR:   take = (brc_dec > 0);
      default:    take = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;  pc <= '0;  ret_pc <= '0;  in_sub <= 1'b0;  play <= 1'b0;
      ptr <= '0;  cnt <= '0;  r_mask <= '0;  r_sel <= '0;  us_left <= '0;  brc <= '0;
      done <= 1'b0;  ret_code <= '0;  fault <= 1'b0;
      reg_we <= 1'b0;  reg_waddr <= '0;  reg_wdata <= '0;
      buf_we <= 1'b0;  buf_addr <= '0;  buf_wdata <= '0;
    end else begin
      done   <= 1'b0;
      reg_we <= 1'b0;
      buf_we <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          pc     <= start_addr;
          in_sub <= 1'b0;
          state  <= S_FETCH;
        end
        S_FETCH: state <= S_EXEC;
        S_EXEC: begin
          r_sel  <= ins.rsel;
          r_mask <= ins.fb;
          pc     <= npc;
          play   <= 1'b0;
          state  <= S_FETCH;
          case (ins.op)
            OP_RDREG: begin
              buf_we <= 1'b1;  buf_addr <= ins.fc;  buf_wdata <= reg_rdata & ins.fa;
            end
            OP_MODREG: begin
              reg_we <= 1'b1;  reg_waddr <= ins.rsel;
              reg_wdata <= (reg_rdata | ins.fa) & ~ins.fb;
            end
            OP_WRREG: begin
              reg_we <= 1'b1;  reg_waddr <= ins.rsel;  reg_wdata <= ins.fa;
            end
            OP_WAIT: if ({ins.fb, ins.fc} != '0) begin
              us_left <= {ins.fb, ins.fc};
              state   <= S_WAIT;
            end
            OP_LDCNT: brc <= BRW'({ins.fb, ins.fc});
            OP_DECBR: begin
              brc <= brc_dec;
              if (take) pc <= tgt;
            end
            OP_BRANY1, OP_BRANY0, OP_BRMATCH: if (take) pc <= tgt;
            OP_END: begin
              state <= S_IDLE;  done <= 1'b1;  ret_code <= ins.fa;  fault <= 1'b0;
            end
            OP_LDPTR: ptr <= ins.fc;
            OP_SUBEND: if (in_sub) begin
              pc <= ret_pc;  in_sub <= 1'b0;
            end else begin
              state <= S_IDLE;  done <= 1'b1;  ret_code <= CODE_ILLEGAL;  fault <= 1'b1;
            end
            OP_SUBCALL: if (in_sub) begin
              state <= S_IDLE;  done <= 1'b1;  ret_code <= CODE_NEST;  fault <= 1'b1;
            end else begin
              ret_pc <= npc;  in_sub <= 1'b1;  pc <= IAW'(ins.fc);
            end
            OP_STREAMO: if (ins.fa != '0) begin
              cnt <= ins.fa;  buf_addr <= ptr;  state <= S_BADDR;
            end
            OP_STREAMI: if (ins.fa != '0) begin
              cnt <= ins.fa;  state <= S_SIN;
            end
            OP_PLAY: if (ins.fa != '0) begin
              cnt <= ins.fa;  play <= 1'b1;  state <= S_PFETCH;
            end
            default: begin
              state <= S_IDLE;  done <= 1'b1;  ret_code <= CODE_ILLEGAL;  fault <= 1'b1;
            end
          endcase
        end
        S_BADDR: state <= S_BDATA;
        S_BDATA: begin
          reg_we <= 1'b1;  reg_waddr <= r_sel;  reg_wdata <= buf_rdata;
          ptr <= ptr + 1'b1;  cnt <= cnt - 1'b1;
          if (cnt == 8'd1) state <= S_FETCH;
          else begin
            buf_addr <= ptr + 1'b1;
            state    <= S_BADDR;
          end
        end
        S_SIN: begin
          buf_we <= 1'b1;  buf_addr <= ptr;  buf_wdata <= reg_rdata & r_mask;
          ptr <= ptr + 1'b1;  cnt <= cnt - 1'b1;
          if (cnt == 8'd1) state <= S_FETCH;
        end
        S_PFETCH: state <= S_PEXEC;
        S_PEXEC: begin
          reg_we <= 1'b1;  reg_waddr <= r_sel;  reg_wdata <= ins.fb;
          pc <= npc;  cnt <= cnt - 1'b1;
          if (ins.fc != '0) begin
            us_left <= {8'd0, ins.fc};
            state   <= S_WAIT;
          end else begin
            state <= (cnt == 8'd1) ? S_FETCH : S_PFETCH;
          end
        end
        S_WAIT: if (tick) begin
          if (us_left == 16'd1) state <= (play && cnt != '0) ? S_PFETCH : S_FETCH;
          else                  us_left <= us_left - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psq_engine.sv
module psq_engine
  import psq_pkg::*;
#(
  parameter int IAW    = 8,
  parameter int US_DIV = 100,
  parameter int BRW    = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [IAW-1:0] start_addr,
  output logic           busy,
  output logic           done,
  output logic [7:0]     ret_code,
  output logic           fault,
  input  logic           load_we,
  input  logic [IAW-1:0] load_addr,
  input  logic [31:0]    load_data,
  output logic [2:0]     reg_raddr,
  input  logic [7:0]     reg_rdata,
  output logic           reg_we,
  output logic [2:0]     reg_waddr,
  output logic [7:0]     reg_wdata,
  input  logic [7:0]     port_status,
  output logic [7:0]     buf_addr,
  output logic           buf_we,
  output logic [7:0]     buf_wdata,
  input  logic [7:0]     buf_rdata
);
  logic [IAW-1:0] imem_addr;
  logic [IW-1:0]  imem_rdata;
  logic           tick_run, tick;

  psq_imem #(.AW(IAW), .W(IW)) i_imem (
    .clk(clk), .we(load_we), .waddr(load_addr), .wdata(load_data),
    .raddr(imem_addr), .rdata(imem_rdata)
  );

  psq_ustick #(.DIV(US_DIV)) i_tick (
    .clk(clk), .rst(rst), .run(tick_run), .tick(tick)
  );

  psq_core #(.IAW(IAW), .BRW(BRW)) i_core (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .busy(busy), .done(done), .ret_code(ret_code), .fault(fault),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .tick_run(tick_run), .tick(tick),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .port_status(port_status),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
  );
endmodule

// File: rtl/psq_engine_chk.sv
module psq_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       fault,
  input logic [7:0] ret_code,
  input logic       reg_we,
  input logic       buf_we,
  input logic [7:0] buf_addr
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                     // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);                                                     // R2
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);                                          // R2
  AST_REG_WR_BUSY: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> busy);                                                    // R3
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (ret_code == 8'hE1 || ret_code == 8'hE2));       // R14
  AST_STREAM_ADDR: assert property (@(posedge clk) disable iff (rst)
    (buf_we && $past(buf_we)) |-> (buf_addr == $past(buf_addr) + 8'd1)); // R12
endmodule

bind psq_engine psq_engine_chk i_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .fault(fault),
  .ret_code(ret_code), .reg_we(reg_we), .buf_we(buf_we), .buf_addr(buf_addr)
);

// File: tb/test_psq_engine.sv
`timescale 1ns/1ps
module test_psq_engine;
  localparam int DIV = 4;
  localparam logic [4:0] RDREG = 5'd2, MODREG = 5'd3, WRREG = 5'd4, WAITU = 5'd5,
    LDCNT = 5'd6, DECBR = 5'd7, BR1 = 5'd8, BR0 = 5'd9, ENDS = 5'd10, LDPTR = 5'd12,
    BRM = 5'd14, SUBEND = 5'd15, SUBCALL = 5'd16, SOUT = 5'd17, SIN = 5'd18, PLAY = 5'd19;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] start_addr = '0;
  logic busy, done, fault;
  logic [7:0] ret_code;
  logic load_we = 1'b0;
  logic [7:0] load_addr = '0;
  logic [31:0] load_data = '0;
  logic [2:0] reg_raddr, reg_waddr;
  logic [7:0] reg_rdata, reg_wdata, buf_addr, buf_wdata;
  logic reg_we, buf_we;
  logic [7:0] port_status = '0;
  logic [7:0] buf_rdata;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  // bench-side port register file and buffer
  logic [7:0] regs [8];
  logic [7:0] bmem [256];
  logic tb_rwe = 1'b0, tb_bwe = 1'b0, lg_clr = 1'b0;
  logic [2:0] tb_ra = '0;
  logic [7:0] tb_ba = '0, tb_d = '0;
  logic [7:0] lg_d [64];
  logic [2:0] lg_a [64];
  int lg_t [64];
  int lg_n = 0;

  always #2.5 clk = ~clk;

  assign reg_rdata = regs[reg_raddr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tb_rwe) regs[tb_ra] <= tb_d;
    if (reg_we) regs[reg_waddr] <= reg_wdata;
    if (tb_bwe) bmem[tb_ba] <= tb_d;
    if (buf_we) bmem[buf_addr] <= buf_wdata;
    buf_rdata <= bmem[buf_addr];
    if (lg_clr) lg_n <= 0;
    else if (reg_we && lg_n < 64) begin
      lg_d[lg_n] <= reg_wdata; lg_a[lg_n] <= reg_waddr; lg_t[lg_n] <= cyc; lg_n <= lg_n + 1;
    end
  end

  psq_engine #(.IAW(8), .US_DIV(DIV), .BRW(16)) i_psq_engine (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .busy(busy), .done(done), .ret_code(ret_code), .fault(fault),
    .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .port_status(port_status),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
  );

  function automatic logic [31:0] mk(input logic [4:0] op, input logic [2:0] rs,
                                     input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    return {op, rs, a, b, c};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] a, input logic [31:0] w);
    @(negedge clk); load_we = 1'b1; load_addr = a; load_data = w;
    @(negedge clk); load_we = 1'b0;
  endtask

  task automatic preg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); tb_rwe = 1'b1; tb_ra = a; tb_d = d;
    @(negedge clk); tb_rwe = 1'b0;
  endtask

  task automatic pbuf(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); tb_bwe = 1'b1; tb_ba = a; tb_d = d;
    @(negedge clk); tb_bwe = 1'b0;
  endtask

  task automatic clrlog();
    @(negedge clk); lg_clr = 1'b1;
    @(negedge clk); lg_clr = 1'b0;
  endtask

  // run from address a; if poke > 0 a second start is pulsed after poke cycles
  task automatic run(input logic [7:0] a, input int poke, output int dur);
    int t0, n;
    @(negedge clk); start_addr = a; start = 1'b1; t0 = cyc;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin
      if (poke > 0 && n == poke) begin start = 1'b1; start_addr = 8'h70; end
      else start = 1'b0;
      @(negedge clk); n++;
    end
    start = 1'b0;
    chk("R2 done seen", int'(done), 1);
    dur = cyc - t0;
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 fault", int'(fault), 0);
    chk("R1 reg_we", int'(reg_we), 0);
    chk("R1 buf_we", int'(buf_we), 0);
  endtask

  task automatic t_regops();
    int d;
    preg(3'd3, 8'h80);
    load(8'h60, mk(WRREG, 3'd2, 8'h5A, 8'h00, 8'h00));
    load(8'h61, mk(MODREG, 3'd2, 8'h81, 8'h0A, 8'h00));
    load(8'h62, mk(MODREG, 3'd3, 8'h01, 8'h01, 8'h00));
    load(8'h63, mk(ENDS, 3'd0, 8'h33, 8'h00, 8'h00));
    run(8'h60, 0, d);
    chk("R2 ret_code", int'(ret_code), 'h33);
    chk("R2 fault clear", int'(fault), 0);
    @(negedge clk);
    chk("R2 done one cycle", int'(done), 0);
    chk("R2 busy low", int'(busy), 0);
    chk("R3 set then clear", int'(regs[2]), 'hD1);
    chk("R3 clear wins", int'(regs[3]), 'h80);
  endtask

  task automatic t_rdreg();
    int d;
    preg(3'd4, 8'hF3);
    load(8'h68, mk(RDREG, 3'd4, 8'h3C, 8'h00, 8'h10));
    load(8'h69, mk(ENDS, 3'd0, 8'h01, 8'h00, 8'h00));
    run(8'h68, 0, d);
    @(negedge clk);
    chk("R4 masked fetch", int'(bmem[8'h10]), 'h30);
  endtask

  task automatic t_delay();
    int d0, d1;
    load(8'h70, mk(WAITU, 3'd0, 8'h00, 8'h00, 8'h00));
    load(8'h71, mk(ENDS, 3'd0, 8'h44, 8'h00, 8'h00));
    load(8'h74, mk(WAITU, 3'd0, 8'h00, 8'h00, 8'd10));
    load(8'h75, mk(ENDS, 3'd0, 8'h45, 8'h00, 8'h00));
    run(8'h70, 0, d0);
    chk("R5 zero wait code", int'(ret_code), 'h44);
    run(8'h74, 0, d1);
    chk("R5 wait length", d1 - d0, 10 * DIV);
    // start pulsed mid-wait must not redirect or restart the run
    run(8'h74, 12, d1);
    chk("R2 start ignored code", int'(ret_code), 'h45);
    chk("R2 start ignored length", d1 - d0, 10 * DIV);
  endtask

  task automatic t_loop();
    int d;
    load(8'h78, mk(LDCNT, 3'd0, 8'h00, 8'h00, 8'd3));
    load(8'h79, mk(WRREG, 3'd5, 8'h77, 8'h00, 8'h00));
    load(8'h7A, mk(DECBR, 3'd0, 8'h00, 8'h00, 8'hFE));
    load(8'h7B, mk(ENDS, 3'd0, 8'h00, 8'h00, 8'h00));
    load(8'h80, mk(LDCNT, 3'd0, 8'h00, 8'h00, 8'd0));
    load(8'h81, mk(WRREG, 3'd5, 8'h77, 8'h00, 8'h00));
    load(8'h82, mk(DECBR, 3'd0, 8'h00, 8'h00, 8'hFE));
    load(8'h83, mk(ENDS, 3'd0, 8'h00, 8'h00, 8'h00));
    clrlog();
    run(8'h78, 0, d);
    @(negedge clk);
    chk("R6 R9 loop of three", lg_n, 3);
    clrlog();
    run(8'h80, 0, d);
    @(negedge clk);
    chk("R6 zero count single pass", lg_n, 1);
  endtask

  task automatic t_branch();
    int d;
    load(8'h10, mk(BR1, 3'd0, 8'h40, 8'h00, 8'h01));
    load(8'h11, mk(ENDS, 3'd0, 8'h01, 8'h00, 8'h00));
    load(8'h12, mk(ENDS, 3'd0, 8'h02, 8'h00, 8'h00));
    load(8'h14, mk(BR0, 3'd0, 8'hC0, 8'h00, 8'h01));
    load(8'h15, mk(ENDS, 3'd0, 8'h01, 8'h00, 8'h00));
    load(8'h16, mk(ENDS, 3'd0, 8'h02, 8'h00, 8'h00));
    load(8'h18, mk(BRM, 3'd0, 8'h50, 8'h08, 8'h01));
    load(8'h19, mk(ENDS, 3'd0, 8'h01, 8'h00, 8'h00));
    load(8'h1A, mk(ENDS, 3'd0, 8'h02, 8'h00, 8'h00));
    port_status = 8'h40; run(8'h10, 0, d); chk("R7 R9 any-set taken", int'(ret_code), 2);
    port_status = 8'hBF; run(8'h10, 0, d); chk("R7 any-set not taken", int'(ret_code), 1);
    port_status = 8'h40; run(8'h14, 0, d); chk("R7 any-clear taken", int'(ret_code), 2);
    port_status = 8'hC0; run(8'h14, 0, d); chk("R7 any-clear not taken", int'(ret_code), 1);
    port_status = 8'h58; run(8'h18, 0, d); chk("R8 forbidden bit set", int'(ret_code), 1);
    port_status = 8'h70; run(8'h18, 0, d); chk("R8 match taken", int'(ret_code), 2);
    port_status = 8'h40; run(8'h18, 0, d); chk("R8 required bit missing", int'(ret_code), 1);
    port_status = 8'h00;
  endtask

  task automatic t_sub();
    int d;
    load(8'h20, mk(SUBCALL, 3'd0, 8'h00, 8'h00, 8'h28));
    load(8'h21, mk(WRREG, 3'd6, 8'h11, 8'h00, 8'h00));
    load(8'h22, mk(ENDS, 3'd0, 8'h05, 8'h00, 8'h00));
    load(8'h28, mk(WRREG, 3'd6, 8'h22, 8'h00, 8'h00));
    load(8'h29, mk(SUBEND, 3'd0, 8'h00, 8'h00, 8'h00));
    clrlog();
    run(8'h20, 0, d);
    @(negedge clk);
    chk("R10 return code", int'(ret_code), 5);
    chk("R10 write count", lg_n, 2);
    chk("R10 sub body first", int'(lg_d[0]), 'h22);
    chk("R10 resumes after call", int'(lg_d[1]), 'h11);
  endtask

  task automatic t_fault();
    int d;
    load(8'h30, mk(SUBCALL, 3'd0, 8'h00, 8'h00, 8'h34));
    load(8'h31, mk(ENDS, 3'd0, 8'h00, 8'h00, 8'h00));
    load(8'h34, mk(SUBCALL, 3'd0, 8'h00, 8'h00, 8'h38));
    load(8'h35, mk(SUBEND, 3'd0, 8'h00, 8'h00, 8'h00));
    load(8'h3A, mk(5'd20, 3'd0, 8'h00, 8'h00, 8'h00));
    load(8'h3C, mk(SUBEND, 3'd0, 8'h00, 8'h00, 8'h00));
    run(8'h30, 0, d);
    chk("R14 nested call fault", int'(fault), 1);
    chk("R14 nested call code", int'(ret_code), 'hE1);
    run(8'h3A, 0, d);
    chk("R14 undefined op fault", int'(fault), 1);
    chk("R14 undefined op code", int'(ret_code), 'hE2);
    run(8'h3C, 0, d);
    chk("R14 stray subend code", int'(ret_code), 'hE2);
  endtask

  task automatic t_stream();
    int d;
    pbuf(8'h20, 8'h11); pbuf(8'h21, 8'h22); pbuf(8'h22, 8'h33); pbuf(8'h25, 8'hEE);
    load(8'h40, mk(LDPTR, 3'd0, 8'h00, 8'h00, 8'h20));
    load(8'h41, mk(SOUT, 3'd7, 8'd3, 8'h00, 8'h00));
    load(8'h42, mk(SIN, 3'd7, 8'd2, 8'h0F, 8'h00));
    load(8'h43, mk(ENDS, 3'd0, 8'h07, 8'h00, 8'h00));
    clrlog();
    run(8'h40, 0, d);
    @(negedge clk);
    chk("R11 write count", lg_n, 3);
    chk("R11 byte 0", int'(lg_d[0]), 'h11);
    chk("R11 byte 1", int'(lg_d[1]), 'h22);
    chk("R11 byte 2", int'(lg_d[2]), 'h33);
    chk("R12 first store", int'(bmem[8'h23]), 'h03);
    chk("R12 second store", int'(bmem[8'h24]), 'h03);
    chk("R12 stops at count", int'(bmem[8'h25]), 'hEE);
  endtask

  task automatic t_play();
    int d;
    load(8'h50, mk(PLAY, 3'd0, 8'd3, 8'h00, 8'h00));
    load(8'h51, mk(5'd0, 3'd0, 8'h00, 8'hA1, 8'd2));
    load(8'h52, mk(5'd0, 3'd0, 8'h00, 8'hA2, 8'd0));
    load(8'h53, mk(5'd0, 3'd0, 8'h00, 8'hA3, 8'd1));
    load(8'h54, mk(ENDS, 3'd0, 8'h09, 8'h00, 8'h00));
    clrlog();
    run(8'h50, 0, d);
    @(negedge clk);
    chk("R13 resumes after list", int'(ret_code), 9);
    chk("R13 write count", lg_n, 3);
    chk("R13 data order", int'({lg_d[0], lg_d[1], lg_d[2]}), 'hA1A2A3);
    chk("R13 target register", int'(lg_a[1]), 0);
    chk("R13 gap with delay", lg_t[1] - lg_t[0], 2 + 2 * DIV);
    chk("R13 gap zero delay", lg_t[2] - lg_t[1], 2);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = '0;
    for (int i = 0; i < 256; i++) bmem[i] = '0;
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regops();
    t_rdreg();
    t_delay();
    t_loop();
    t_branch();
    t_sub();
    t_fault();
    t_stream();
    t_play();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule